// File: doc/BRIEF.md
# Serial CRC Receive Checker

This block checks one received codeword at a time, one bit per valid cycle. The codeword is the message bits followed by the frame check bits, most significant bit first. A start pulse clears the divider register. Each valid bit then enters the register at its low-order stage. The bit is added modulo 2 to the feedback from the top stage, and the feedback goes to every stage whose generator coefficient is 1. The divider therefore performs a true modulo-2 division of the whole codeword by the generator. When the bit marked as last has been taken in, the block raises a done flag. It also raises an error flag whenever the remainder left in the register is nonzero.

Once done is high, further valid cycles unload the remainder. Zeros are shifted into the low end with the feedback path cut, and the top stage always appears on the serial remainder output. A receiver can use this to log or inspect the syndrome. The generator is a parameter. Its leading and trailing coefficients are 1, and only the middle taps are built from its value.

Top module: `crc_rx_checker`

## Requirements
- R1: A start pulse clears the divider register, the done flag and the error flag; done_o is low on the cycle after start_i.
- R2: Bits are taken only in cycles with bit_vld_i high, most significant first. Cycles with bit_vld_i low leave the register and the outputs unchanged.
- R3: The generator is the parameter POLY of degree CRC_W (default 6'b100111, CRC_W = 5). Each bit is added to the register's lowest stage, and the top stage is fed back into every stage j with POLY[j] = 1.
- R4: done_o and err_o are registered. They become valid on the cycle after the bit taken with last_i high, and they hold until the next start.
- R5: err_o is 0 exactly when the remainder after the final bit is all zero. The codeword 10000000 followed by 11010 checks clean under the default generator.
- R6: Every single-bit error in a codeword sets err_o.
- R7: Every burst of 5 or fewer bits, and every odd number of bit errors, sets err_o under the default generator.
- R8: While done_o is high, each valid cycle shifts the register toward its top with a 0 entering stage 0 and no feedback. rem_o always shows the top stage, so the remainder appears most significant bit first.
- R9: With CRC_W = 4 and POLY = 5'b11001, the codeword 11100110 followed by 0110 checks clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears state before a new codeword |
| bit_vld_i | input | 1 | Qualifies bit_i and last_i; in unload phase, shifts the remainder |
| bit_i | input | 1 | Received bit, msb first |
| last_i | input | 1 | Marks the final bit of the codeword |
| err_o | output | 1 | Nonzero remainder after the final bit |
| done_o | output | 1 | Check complete, held until the next start |
| rem_o | output | 1 | Top stage of the register (serial remainder) |

## Verification
A wrong tap or a wrong feedback stage corrupts the register on the first cycle in which the top stage is 1. It shows only at the end of the word: as a wrong err_o on the cycle after the last bit, or as a wrong bit on rem_o during unload. Flipping each bit position in turn, and unloading the remainder bit by bit, pins a faulty stage down to a specific cycle. Control faults show at once: done_o missing one cycle after the last bit, or done_o failing to drop one cycle after start.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;
  typedef enum logic {
    PH_RECV = 1'b0,
    PH_DONE = 1'b1
  } chk_phase_e;
endpackage

// File: rtl/crc_div_reg.sv
module crc_div_reg #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] TAPS = 5'b00111
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         fb_en_i,
  input  logic         din_i,
  output logic [W-1:0] state_o,
  output logic         nxt_zero_o
);
  logic [W-1:0] q, d;
  logic fb;

  assign fb = fb_en_i & q[W-1];

  for (genvar j = 0; j < W; j++) begin : g_stage
    if (j == 0) begin : g_low
      assign d[j] = (din_i & fb_en_i) ^ (fb & TAPS[j]);
    end else begin : g_up
      assign d[j] = q[j-1] ^ (fb & TAPS[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (en_i)  q <= d;
  end

  assign state_o    = q;
  assign nxt_zero_o = (d == '0);

  // unload fills with zeros
  p_unload_zero_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fb_en_i && !clr_i) |=> (q[0] == 1'b0));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(q));
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q == '0));
endmodule

// File: rtl/crc_chk_ctrl.sv
module crc_chk_ctrl
  import crc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic last_i,
  input  logic nxt_zero_i,
  output logic div_clr_o,
  output logic div_en_o,
  output logic fb_en_o,
  output logic err_o,
  output logic done_o
);
  chk_phase_e phase;
  logic fin;

  assign fin       = bit_vld_i & last_i & (phase == PH_RECV) & ~start_i;
  assign div_clr_o = start_i;
  assign div_en_o  = bit_vld_i & ~start_i;
  assign fb_en_o   = (phase == PH_RECV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= PH_RECV;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i) begin
      phase  <= PH_RECV;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (fin) begin
      phase  <= PH_DONE;
      done_o <= 1'b1;
      err_o  <= ~nxt_zero_i;
    end
  end

  p_start_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !err_o));
  p_done_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && last_i && !done_o && !start_i) |=> done_o);
  p_done_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(err_o)));
  p_err_needs_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

// File: rtl/crc_rx_checker.sv
module crc_rx_checker #(
  parameter int unsigned CRC_W = 5,
  parameter logic [CRC_W:0] POLY = 6'b100111
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic last_i,
  output logic err_o,
  output logic done_o,
  output logic rem_o
);
  localparam logic [CRC_W-1:0] TAPS = POLY[CRC_W-1:0];

  logic div_clr, div_en, fb_en, nxt_zero;
  logic [CRC_W-1:0] state;

  crc_chk_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bit_vld_i  (bit_vld_i),
    .last_i     (last_i),
    .nxt_zero_i (nxt_zero),
    .div_clr_o  (div_clr),
    .div_en_o   (div_en),
    .fb_en_o    (fb_en),
    .err_o      (err_o),
    .done_o     (done_o)
  );

  crc_div_reg #(.W(CRC_W), .TAPS(TAPS)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (div_clr),
    .en_i       (div_en),
    .fb_en_i    (fb_en),
    .din_i      (bit_i),
    .state_o    (state),
    .nxt_zero_o (nxt_zero)
  );

  assign rem_o = state[CRC_W-1];

  p_rem_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bit_vld_i && !start_i) |=> (rem_o == $past(state[CRC_W-2])));
endmodule

// File: tb/crc_rx_checker_bench.sv
module crc_rx_checker_bench;
  localparam int W = 5;
  localparam logic [W:0] GEN = 6'b100111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, vld = 0, din = 0, last = 0;
  logic err, done, rem;
  logic start_b = 0, vld_b = 0, din_b = 0, last_b = 0;
  logic err_b, done_b, rem_b;
  int checks = 0, errors = 0;

  bit    exp_q[$];
  string tag_q[$];
  logic  done_q = 1'b0;

  always #2 clk = ~clk;

  crc_rx_checker u_crc_rx_checker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bit_vld_i(vld),
    .bit_i(din), .last_i(last), .err_o(err), .done_o(done), .rem_o(rem));

  crc_rx_checker #(.CRC_W(4), .POLY(5'b11001)) u_crc_rx_checker_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .bit_vld_i(vld_b),
    .bit_i(din_b), .last_i(last_b), .err_o(err_b), .done_o(done_b), .rem_o(rem_b));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // polynomial long division over the whole codeword
  function automatic logic [W-1:0] ref_rem(input logic [63:0] v, input int len);
    for (int i = len - 1; i >= W; i--)
      if (v[i]) v = v ^ (64'(GEN) << (i - W));
    return v[W-1:0];
  endfunction

  // monitor: one expected flag per completed word
  always @(negedge clk) begin
    if (done && !done_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected done actual=1 expected=0");
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, err, e);
      end
    end
    done_q <= done;
  end

  task automatic send(input logic [63:0] w, input int len, input bit exp_err,
                      input string tag, input bit gaps);
    exp_q.push_back(exp_err);
    tag_q.push_back(tag);
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    for (int i = len - 1; i >= 0; i--) begin
      vld = 1; din = w[i]; last = (i == 0);
      @(posedge clk); #1 vld = 0; last = 0; din = 0;
      if (gaps) begin din = ~w[i]; last = 1; @(posedge clk); #1 din = 0; last = 0; end
    end
    @(posedge clk); #1;
  endtask

  task automatic unload(input logic [W-1:0] exp_rem, input string tag);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk); chk(tag, rem, exp_rem[i]);
      @(posedge clk); #1 vld = 1;
      @(posedge clk); #1 vld = 0;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    automatic logic [63:0] cw = 64'b1000000011010;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset err", err, 1'b0);
    chk("R1 reset rem", rem, 1'b0);

    // R5 R3 clean word
    send(cw, 13, 1'b0, "R5 clean codeword", 1'b0);
    @(negedge clk); chk("R4 done held", done, 1'b1);
    unload('0, "R8 clean remainder");
    // R2 clean with idle gaps between bits
    send(cw, 13, 1'b0, "R2 clean with gaps", 1'b1);
    // R1 start drops done
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk); chk("R1 done cleared", done, 1'b0);

    // R6 each single flip
    for (int p = 0; p < 13; p++)
      send(cw ^ (64'd1 << p), 13, 1'b1, $sformatf("R6 flip bit %0d", p), 1'b0);

    // R7 bursts of length 2..5
    for (int l = 2; l <= 5; l++)
      for (int s = 0; s + l <= 13; s += 4)
        send(cw ^ (((64'd1 << l) - 1) << s), 13, 1'b1,
             $sformatf("R7 burst len %0d at %0d", l, s), 1'b0);
    // R7 odd error counts
    send(cw ^ 64'b1000010001, 13, 1'b1, "R7 three errors a", 1'b0);
    send(cw ^ 64'b1000000000110, 13, 1'b1, "R7 three errors b", 1'b0);
    send(cw ^ 64'b1101011000000, 13, 1'b1, "R7 five errors", 1'b0);

    // R8 unload of a nonzero remainder
    send(cw ^ (64'd1 << 12), 13, 1'b1, "R8 syndrome word", 1'b0);
    unload(ref_rem(cw ^ (64'd1 << 12), 13), "R8 remainder bit");
    send(cw ^ 64'b111, 13, 1'b1, "R8 syndrome word 2", 1'b0);
    unload(ref_rem(cw ^ 64'b111, 13), "R8 remainder bit 2");

    // R9 second generator
    begin
      automatic logic [11:0] cb = 12'b111001100110;
      @(posedge clk); #1 start_b = 1;
      @(posedge clk); #1 start_b = 0;
      for (int i = 11; i >= 0; i--) begin
        vld_b = 1; din_b = cb[i]; last_b = (i == 0);
        @(posedge clk); #1 vld_b = 0; last_b = 0;
      end
      @(negedge clk);
      chk("R9 done", done_b, 1'b1);
      chk("R9 clean", err_b, 1'b0);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R4 all words reported", 1'(exp_q.size() == 0), 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule